// File: doc/BRIEF.md
# Rheostat Wiper Register with One-Time Store Controller

This block keeps the 10-bit wiper code of a digital rheostat and manages a write-once store of up to `NSLOT` saved settings, built as a register bank that is cleared only at power-on. An upstream serial front end gives it one 16-bit command frame at a time. Each frame holds two guard bits that must be zero, a 4-bit opcode and a 10-bit operand. The commands set the wiper, read it back, commit the present wiper value to the next free slot, read a slot, and read a fixed resistor-tolerance word.

All slow operations run on a busy timer. While the timer runs, frames are ignored. The parameters `WR_CYC`, `PROG_CYC`, `MRD_CYC`, `RST_CYC` and `POR_CYC` set the busy windows in clock cycles. The window starts at the edge that accepts the command and lasts exactly that many cycles. The result takes effect at the edge that ends the window.

After power-on (`rst_n` low), or after a pulse on `restore_req`, the wiper is reloaded from the most recently committed slot. If the store is empty it is loaded with midscale. Once every slot is used, the wiper is frozen.

Top module: `wiper_otp_ctrl`

## Requirements
- R1: While `rst_n` is low, and for `POR_CYC` cycles after it rises, `busy` is 1. After that, `wiper` is 0x200, `err` is 0 and every slot reads back as 0.
- R2: A frame whose bits [15:14] are not 00 is ignored: no busy window, no response, no state change. The same holds for a frame whose opcode (bits [13:10]) is not one of 1, 2, 3, 5 or 6.
- R3: Opcode 1 (set wiper) with the store not full makes `busy` high for `WR_CYC` cycles. `wiper` then equals operand bits [9:0].
- R4: Opcode 2 (read wiper) gives a single-cycle `resp_valid` with `resp_data` equal to `wiper` on the cycle after acceptance, and it opens no busy window.
- R5: Opcode 3 (commit) writes `wiper` into slot number `used` and advances `used` by one. It holds `busy` for `PROG_CYC` cycles.
- R6: Opcode 3 is rejected when all `NSLOT` slots are used, or when `wiper` equals the last committed value. A rejected commit consumes no slot, opens no busy window and sets `err`.
- R7: Once all slots are used, opcode 1 is ignored and the wiper keeps its value.
- R8: A high `restore_req` opens a `RST_CYC` busy window, even while busy, and abandons any pending operation. `wiper` then equals the last committed value, or 0x200 if nothing was committed.
- R9: Opcode 5 holds `busy` for `MRD_CYC` cycles and then pulses `resp_valid`. `resp_data` is the content of the slot whose index is the operand. A slot not yet committed, or an index of `NSLOT` or above, reads as 0.
- R10: Opcode 6 holds `busy` for `MRD_CYC` cycles and then returns the parameter `TOL_WORD` on `resp_data`.
- R11: A frame that arrives while `busy` is high is ignored.
- R12: `err` is sticky: only `rst_n` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset; clears the store |
| restore_req | input | 1 | Restore request; reloads wiper from store |
| frame_valid | input | 1 | Frame present on `frame` this cycle |
| frame | input | 16 | Command frame: guard[15:14], opcode[13:10], operand[9:0] |
| wiper | output | 10 | Current wiper code |
| busy | output | 1 | Timed operation in progress; frames ignored |
| resp_valid | output | 1 | One-cycle strobe for `resp_data` |
| resp_data | output | 10 | Read-back value |
| err | output | 1 | Sticky rejected-commit flag |

## Verification
The assertions assume that `frame_valid` and `restore_req` are sampled only at rising edges and that every timing parameter is at least 1. Under those conditions, `used` can only hold or step by one, and the wiper cannot move inside a busy window. The stimulus drives inputs on falling edges and normally waits for `busy` to drop before the next frame. One directed case sends a frame into an open window to exercise the ignore path. Random frames come from a fixed seed and include malformed guard bits and unused opcodes. Directed sequences fill the store, repeat a commit of the same value, and pulse restore both with an empty store and with a full one.

// File: rtl/wiper_otp_pkg.sv
// Shared types for the wiper/one-time-store controller.
// Assumes a 16-bit frame: guard[15:14], opcode[13:10], operand[9:0].
package wiper_otp_pkg;
    localparam int CODE_W = 10;
    localparam logic [CODE_W-1:0] MIDSCALE = 10'h200;

    typedef enum logic [3:0] {
        OPC_SET  = 4'h1,
        OPC_RDW  = 4'h2,
        OPC_COMMIT = 4'h3,
        OPC_MRD  = 4'h5,
        OPC_TOL  = 4'h6
    } opcode_t;

    typedef enum logic [2:0] {
        PEND_NONE, PEND_SET, PEND_COMMIT, PEND_MRD, PEND_TOL, PEND_RESTORE
    } pend_t;
endpackage

// File: rtl/frame_decode.sv
// Splits a command frame into a legal-command flag, an opcode and an operand.
// Assumes nothing about timing; purely combinational.
module frame_decode
    import wiper_otp_pkg::*;
(
    input  logic [15:0]       frame,
    output logic              legal,
    output opcode_t           opc,
    output logic [CODE_W-1:0] operand
);
    // Guard bits must be zero and the opcode must be one of the known codes.
    always_comb begin
        opc     = opcode_t'(frame[13:10]);
        operand = frame[CODE_W-1:0];
        legal   = (frame[15:14] == 2'b00) &&
                  (frame[13:10] inside {4'h1, 4'h2, 4'h3, 4'h5, 4'h6});
    end
endmodule

// File: rtl/busy_timer.sv
// Down-counter that marks a busy window of a loaded length.
// Assumes load values are >= 1; reset loads RST_LOAD so power-on is busy.
module busy_timer #(
    parameter int CW       = 8,
    parameter int RST_LOAD = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          busy,
    output logic          done
);
    logic [CW-1:0] cnt;

    // Count down from the loaded window length to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= CW'(RST_LOAD);
        else if (load)    cnt <= load_val;
        else if (cnt != 0) cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != 0);
    assign done = (cnt == 1) && !load;
endmodule

// File: rtl/otp_bank.sv
// Write-once slot bank modelling the fuse store; slots fill in order.
// Assumes prog_en only when not full; cleared only by power-on reset.
module otp_bank
    import wiper_otp_pkg::*;
#(
    parameter int NSLOT = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic [CODE_W-1:0] prog_data,
    input  logic [CODE_W-1:0] rd_addr,
    output logic [CODE_W-1:0] rd_data,
    output logic [CODE_W-1:0] last_val,
    output logic              empty,
    output logic              full
);
    localparam int UW = $clog2(NSLOT + 1);

    logic [CODE_W-1:0] slot [NSLOT];
    logic [UW-1:0]     used;

    // Each slot is blown once, at index used, then used advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used <= '0;
            for (int i = 0; i < NSLOT; i++) slot[i] <= '0;
        end else if (prog_en && !full) begin
            slot[used] <= prog_data;
            used       <= used + 1'b1;
        end
    end

    // Read port and last-committed value.
    always_comb begin
        rd_data  = (int'(rd_addr) < NSLOT) ? slot[rd_addr] : '0;
        last_val = (used != 0) ? slot[used - 1'b1] : MIDSCALE;
        empty    = (used == 0);
        full     = (int'(used) == NSLOT);
    end

    a_r5_used_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(used) <= NSLOT);
    a_r5_used_step: assert property (@(posedge clk) disable iff (!rst_n)
        (used == $past(used)) || (used == $past(used) + 1'b1));
endmodule

// File: rtl/wiper_otp_ctrl.sv
// Wiper register and one-time store controller. Accepts frames when idle,
// runs timed operations on a busy timer and commits results at window end.
// Assumes one frame per cycle at most and all timing parameters >= 1.
module wiper_otp_ctrl
    import wiper_otp_pkg::*;
#(
    parameter int NSLOT    = 50,
    parameter int WR_CYC   = 30,
    parameter int PROG_CYC = 17_500_000,
    parameter int MRD_CYC  = 300,
    parameter int RST_CYC  = 30_000,
    parameter int POR_CYC  = 100_000,
    parameter logic [9:0] TOL_WORD = 10'h0F3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        restore_req,
    input  logic        frame_valid,
    input  logic [15:0] frame,
    output logic [9:0]  wiper,
    output logic        busy,
    output logic        resp_valid,
    output logic [9:0]  resp_data,
    output logic        err
);
    function automatic int max5(int a, int b, int c, int d, int e);
        int m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        if (e > m) m = e;
        return m;
    endfunction

    localparam int TMAX = max5(WR_CYC, PROG_CYC, MRD_CYC, RST_CYC, POR_CYC);
    localparam int CW   = $clog2(TMAX + 1);

    logic              legal, accept, tmr_load, tmr_done, prog_en;
    logic              full, empty, reject;
    opcode_t           opc;
    logic [CODE_W-1:0] operand, rd_data, last_val, pend_data;
    logic [CW-1:0]     tmr_val;
    pend_t             pend;

    frame_decode u_dec (.frame(frame), .legal(legal), .opc(opc), .operand(operand));

    busy_timer #(.CW(CW), .RST_LOAD(POR_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .busy(busy), .done(tmr_done));

    otp_bank #(.NSLOT(NSLOT)) u_bank (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .prog_data(wiper),
        .rd_addr(pend_data), .rd_data(rd_data), .last_val(last_val),
        .empty(empty), .full(full));

    // Frames are taken only when idle and no restore is requested.
    assign accept = frame_valid && legal && !busy && !restore_req;
    assign reject = accept && (opc == OPC_COMMIT) &&
                    (full || (!empty && wiper == last_val));
    assign prog_en = tmr_done && (pend == PEND_COMMIT);

    // Choose whether and how long to open a busy window.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (restore_req) begin
            tmr_load = 1'b1;
            tmr_val  = CW'(RST_CYC);
        end else if (accept) begin
            unique case (opc)
                OPC_SET:    if (!full) begin tmr_load = 1'b1; tmr_val = CW'(WR_CYC); end
                OPC_COMMIT: if (!reject) begin tmr_load = 1'b1; tmr_val = CW'(PROG_CYC); end
                OPC_MRD,
                OPC_TOL:    begin tmr_load = 1'b1; tmr_val = CW'(MRD_CYC); end
                default:    ;
            endcase
        end
    end

    // Record the pending operation and its operand when a window opens.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= PEND_RESTORE;
            pend_data <= '0;
        end else if (restore_req) begin
            pend <= PEND_RESTORE;
        end else if (tmr_load) begin
            pend_data <= operand;
            unique case (opc)
                OPC_SET:    pend <= PEND_SET;
                OPC_COMMIT: pend <= PEND_COMMIT;
                OPC_MRD:    pend <= PEND_MRD;
                default:    pend <= PEND_TOL;
            endcase
        end else if (tmr_done) begin
            pend <= PEND_NONE;
        end
    end

    // Commit wiper updates and responses at the end of a window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wiper      <= MIDSCALE;
            resp_valid <= 1'b0;
            resp_data  <= '0;
        end else begin
            resp_valid <= 1'b0;
            if (accept && opc == OPC_RDW) begin
                resp_valid <= 1'b1;
                resp_data  <= wiper;
            end else if (tmr_done) begin
                unique case (pend)
                    PEND_SET:     wiper <= pend_data;
                    PEND_RESTORE: wiper <= last_val;
                    PEND_MRD:     begin resp_valid <= 1'b1; resp_data <= rd_data; end
                    PEND_TOL:     begin resp_valid <= 1'b1; resp_data <= TOL_WORD; end
                    default:      ;
                endcase
            end
        end
    end

    // Sticky error on a rejected commit.
    always_ff @(posedge clk) begin
        if (!rst_n)      err <= 1'b0;
        else if (reject) err <= 1'b1;
    end

    a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    a_r6_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(frame_valid));
    a_r11_wiper_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tmr_done) |=> $stable(wiper));
    a_r4_resp_idle: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !busy);
    a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !busy && !restore_req) |=> $stable(wiper));
endmodule

// File: tb/sim_wiper_otp_ctrl.sv
module sim_wiper_otp_ctrl;
    localparam int NSLOT = 50, WR = 3, PRG = 20, MRD = 5, RST = 8, POR = 12;
    localparam logic [9:0] TOL = 10'h0F3;

    logic clk = 0, rst_n = 0, restore_req = 0, frame_valid = 0;
    logic [15:0] frame = '0;
    logic [9:0] wiper, resp_data;
    logic busy, resp_valid, err;

    int checks = 0, errors = 0, resp_cnt = 0;
    logic [9:0] got;
    logic [9:0] m_slot [NSLOT];
    int m_used = 0;
    logic [9:0] m_wiper = 10'h200;
    logic m_err = 0;

    always #10 clk = ~clk;

    wiper_otp_ctrl #(.NSLOT(NSLOT), .WR_CYC(WR), .PROG_CYC(PRG), .MRD_CYC(MRD),
        .RST_CYC(RST), .POR_CYC(POR), .TOL_WORD(TOL)) u0 (
        .clk(clk), .rst_n(rst_n), .restore_req(restore_req),
        .frame_valid(frame_valid), .frame(frame), .wiper(wiper), .busy(busy),
        .resp_valid(resp_valid), .resp_data(resp_data), .err(err));

    always @(negedge clk) if (resp_valid) begin got = resp_data; resp_cnt++; end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] m_last();
        return (m_used == 0) ? 10'h200 : m_slot[m_used-1];
    endfunction

    function automatic logic [9:0] m_read(input logic [9:0] a);
        return (int'(a) < m_used) ? m_slot[a] : 10'h0;
    endfunction

    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        @(negedge clk);
    endtask

    task automatic send(input logic [15:0] f, output int n);
        @(negedge clk); frame_valid = 1; frame = f;
        @(negedge clk); frame_valid = 0;
        wait_idle(n);
    endtask

    task automatic do_restore(input string req);
        int n;
        @(negedge clk); restore_req = 1;
        @(negedge clk); restore_req = 0;
        wait_idle(n);
        m_wiper = m_last();
        chk(req, n, RST);
        chk(req, wiper, m_wiper);
    endtask

    task automatic do_set(input logic [9:0] d);
        int n;
        send({6'b000001, d}, n);
        if (m_used < NSLOT) begin m_wiper = d; chk("R3 busy", n, WR); end
        else chk("R7 busy", n, 0);
        chk("R3/R7 wiper", wiper, m_wiper);
    endtask

    task automatic do_commit();
        int n;
        send({6'b000011, 10'h0}, n);
        if (m_used == NSLOT || (m_used != 0 && m_wiper == m_last())) begin
            m_err = 1;
            chk("R6 busy", n, 0);
        end else begin
            m_slot[m_used] = m_wiper; m_used++;
            chk("R5 busy", n, PRG);
        end
        chk("R6/R12 err", err, m_err);
    endtask

    task automatic do_read(input logic [3:0] opc, input logic [9:0] d, input logic [9:0] exp,
                           input int ebusy, input string req);
        int n, c;
        c = resp_cnt;
        send({2'b00, opc, d}, n);
        chk(req, n, ebusy);
        chk(req, resp_cnt - c, 1);
        chk(req, got, exp);
    endtask

    task automatic do_ignored(input logic [15:0] f, input string req);
        int n, c;
        c = resp_cnt;
        send(f, n);
        chk(req, n, 0);
        chk(req, resp_cnt - c, 0);
        chk(req, wiper, m_wiper);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        logic [3:0] bad;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        wait_idle(n);
        chk("R1 por busy", n, POR);
        chk("R1 wiper", wiper, 10'h200);
        chk("R1 err", err, 0);
        do_read(4'h5, 10'd0, 10'h0, MRD, "R1 slot0");
        do_restore("R8 empty restore");
        do_read(4'h6, 10'h0, TOL, MRD, "R10 tol");
        do_set(10'h155);
        do_read(4'h2, 10'h0, 10'h155, 0, "R4 rdw");
        do_commit();
        do_commit();
        do_read(4'h5, 10'd0, 10'h155, MRD, "R9 slot0");
        do_read(4'h5, 10'd63, 10'h0, MRD, "R9 oob");
        do_ignored({2'b10, 4'h1, 10'h3FF}, "R2 guard");
        do_ignored({2'b00, 4'h4, 10'h3FF}, "R2 opcode");
        // R11: frame during a busy window is ignored
        @(negedge clk); frame_valid = 1; frame = {6'b000001, 10'h2AA};
        @(negedge clk); frame = {6'b000001, 10'h011};
        @(negedge clk); frame_valid = 0;
        m_wiper = 10'h2AA;
        wait_idle(n);
        chk("R11 busy ignore", wiper, 10'h2AA);
        for (int i = 0; i < 300; i++) begin
            case ($urandom % 8)
                0, 1: do_set(10'($urandom));
                2: do_commit();
                3: begin
                    logic [9:0] a = 10'($urandom % 64);
                    do_read(4'h5, a, m_read(a), MRD, "R9 rand");
                end
                4: do_read(4'h2, 10'($urandom), m_wiper, 0, "R4 rand");
                5: do_ignored({2'($urandom % 3 + 1), 4'($urandom), 10'($urandom)}, "R2 rand guard");
                6: begin
                    bad = 4'($urandom);
                    if (bad inside {4'h1, 4'h2, 4'h3, 4'h5, 4'h6}) bad = 4'h7;
                    do_ignored({2'b00, bad, 10'($urandom)}, "R2 rand opc");
                end
                default: do_restore("R8 rand");
            endcase
        end
        while (m_used < NSLOT) begin
            do_set(m_last() ^ 10'h001 ^ 10'(m_used << 2));
            do_commit();
        end
        do_set(10'h3C3);
        do_commit();
        do_read(4'h5, 10'(NSLOT-1), m_slot[NSLOT-1], MRD, "R9 last slot");
        do_restore("R8 full restore");
        chk("R12 err held", err, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule